// File: doc/BRIEF.md
# Two-Stage Serial Clock Generator

This block turns the system clock into the serial clock of a synchronous serial port and tells the shift engine beside it when to capture and when to launch a data bit. Two dividers are cascaded: the first divides by an even prescale value; the second stretches each half-period by an 8-bit rate factor. One full serial clock period therefore lasts prescale × (1 + rate) system clocks. The fastest setting gives half the system clock, and the slowest gives the system clock divided by 254 × 256.

The shift engine pulses `start` with a frame length. The generator takes a copy of the polarity, phase, prescale, rate and length settings at that moment. It clears both divider counters, so the first half-period is full length, and then produces exactly two serial clock edges per bit. On each edge it raises either a capture strobe or a launch strobe, chosen by the clock phase. While idle, the serial clock rests at the polarity level. Clearing the port enable aborts a frame at once.

Top module: `spi_sck_gen`

## Requirements
- R1: Once a frame starts, the serial clock toggles every H system clocks, where H = (P/2) × (1 + rate) and P is the effective prescale. The first toggle comes H clocks after the edge that accepts `start`.
- R2: Bit 0 of `prescale` is ignored, so 7 acts as 6. An effective prescale below 2 (a written value of 0 or 1) acts as 2.
- R3: With an effective prescale of 2 and rate 0, the serial clock toggles on every system clock. With 254 and 255, each half-period lasts 32512 system clocks.
- R4: After reset, while idle and after a frame's final edge, `sck` equals the polarity level. While idle it follows `cpol` one clock later.
- R5: A frame of `bits_m1`+1 bits has exactly 2 × (`bits_m1`+1) serial clock edges. `frame_done` pulses for one clock together with the last edge, and `busy` falls at that same edge.
- R6: Within a bit, edges are numbered first (odd edge of the frame) and second (even edge). With `cpha`=0, `sample_stb` pulses on first edges and `shift_stb` on second edges. With `cpha`=1 the two are swapped. Neither strobe pulses on a cycle without an edge.
- R7: A `start` pulse that arrives while `busy` is high is ignored. A frame started on the clock right after a previous frame ends still gets a full-length first half-period.
- R8: While `enable` is low, `busy` is low, no strobe pulses, `start` is ignored and `sck` follows `cpol`. Dropping `enable` in the middle of a frame ends it on the next clock.
- R9: Changes to `prescale`, `rate`, `bits_m1`, `cpha` or `cpol` during a frame do not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Port enable; low holds the generator idle and cleared |
| start | input | 1 | Frame start request |
| cpol | input | 1 | Clock polarity (idle level) |
| cpha | input | 1 | Clock phase: 0 captures on the first edge of a bit, 1 on the second |
| prescale | input | 8 | First-stage divisor (even, bit 0 ignored) |
| rate | input | 8 | Second-stage factor; half-period multiplied by rate+1 |
| bits_m1 | input | 4 | Frame length in bits, minus one |
| sck | output | 1 | Serial clock |
| sample_stb | output | 1 | Capture strobe, one clock, coincident with an edge |
| shift_stb | output | 1 | Launch strobe, one clock, coincident with an edge |
| busy | output | 1 | A frame is in progress |
| frame_done | output | 1 | One-clock pulse on the final edge of a frame |

## Verification
The bench times every serial clock edge against the half-period it computes for itself. It covers an odd prescale and prescale values of 0 and 1; a generator that honoured bit 0, or divided by zero, would show the wrong spacing or stop toggling. It starts one frame on the clock right after another ends, which catches counters that were left part-way through a count and would give a short first half-period. It also pulses `start` and changes the settings in the middle of a frame; a design that took either would change the spacing or the edge count. Finally, it drops `enable` mid-frame and drives `start` while disabled, and watches that `sck` settles at the polarity level and that no strobe escapes.

// File: rtl/spi_sck_pkg.sv
package spi_sck_pkg;

  // Position of an edge within one bit cell.
  typedef enum logic {
    EDGE_LEAD  = 1'b0,
    EDGE_TRAIL = 1'b1
  } edge_kind_e;

  // True when this edge is the capture edge for the given phase.
  function automatic logic capture_on(input edge_kind_e kind, input logic pha);
    return (kind == EDGE_LEAD) != pha;
  endfunction

endpackage

// File: rtl/spi_sck_prescaler.sv
module spi_sck_prescaler #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic [W-1:0] half,
  output logic         tick
);

  logic [W-1:0] cnt_q;

  assign tick = ~clr & (cnt_q == W'(half - 1'b1));

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // R1
  pre_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q < half);

endmodule

// File: rtl/spi_sck_rate_div.sv
module spi_sck_rate_div #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         tick,
  input  logic [W-1:0] limit,
  output logic         edge_o
);

  logic [W-1:0] cnt_q;

  assign edge_o = tick & (cnt_q == limit);

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt_q <= '0;
    else if (tick)   cnt_q <= edge_o ? '0 : cnt_q + 1'b1;
  end

  // R1
  rate_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= limit);

endmodule

// File: rtl/spi_sck_edge_seq.sv
module spi_sck_edge_seq
  import spi_sck_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             start,
  input  logic             cpol,
  input  logic             cpha,
  input  logic [LEN_W-1:0] bits_m1,
  input  logic             edge_i,
  output logic             sck,
  output logic             sample_stb,
  output logic             shift_stb,
  output logic             busy,
  output logic             frame_done
);

  logic [LEN_W:0] ecnt_q, last_q;
  logic           pol_q, pha_q;
  logic           sck_q, smp_q, shf_q, busy_q, done_q;
  edge_kind_e     kind;
  logic           cap;

  assign kind = ecnt_q[0] ? EDGE_TRAIL : EDGE_LEAD;
  assign cap  = capture_on(kind, pha_q);

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      busy_q <= 1'b0;
      ecnt_q <= '0;
      last_q <= '0;
      pol_q  <= cpol;
      pha_q  <= 1'b0;
      sck_q  <= cpol;
      smp_q  <= 1'b0;
      shf_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      smp_q  <= 1'b0;
      shf_q  <= 1'b0;
      done_q <= 1'b0;
      if (!busy_q) begin
        sck_q <= cpol;
        if (start) begin
          busy_q <= 1'b1;
          ecnt_q <= '0;
          last_q <= {bits_m1, 1'b1};
          pol_q  <= cpol;
          pha_q  <= cpha;
        end
      end else if (edge_i) begin
        sck_q  <= ~sck_q;
        ecnt_q <= ecnt_q + 1'b1;
        smp_q  <= cap;
        shf_q  <= ~cap;
        if (ecnt_q == last_q) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign sck        = sck_q;
  assign sample_stb = smp_q;
  assign shift_stb  = shf_q;
  assign busy       = busy_q;
  assign frame_done = done_q;

  // R4
  end_level_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |-> sck_q == pol_q);

  // R6
  strobe_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (smp_q || shf_q) |-> sck_q != $past(sck_q));

  // R8
  disable_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !busy_q && !smp_q && !shf_q);

  // R5
  edge_count_chk: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> ecnt_q <= last_q);

endmodule

// File: rtl/spi_sck_gen.sv
module spi_sck_gen #(
  parameter  int PRE_W    = 8,
  parameter  int RATE_W   = 8,
  parameter  int MAX_BITS = 16,
  localparam int LEN_W    = $clog2(MAX_BITS),
  localparam int HALF_W   = PRE_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              start,
  input  logic              cpol,
  input  logic              cpha,
  input  logic [PRE_W-1:0]  prescale,
  input  logic [RATE_W-1:0] rate,
  input  logic [LEN_W-1:0]  bits_m1,
  output logic              sck,
  output logic              sample_stb,
  output logic              shift_stb,
  output logic              busy,
  output logic              frame_done
);

  logic [HALF_W-1:0] half_cfg, half_q;
  logic [RATE_W-1:0] rate_q;
  logic              accept, clr, tick, edge_w;

  // Bit 0 dropped; zero half (prescale 0 or 1) becomes one, i.e. divide by 2.
  always_comb begin
    half_cfg = prescale[PRE_W-1:1];
    if (half_cfg == '0) half_cfg = HALF_W'(1);
  end

  assign accept = start & enable & ~busy;
  assign clr    = ~busy | ~enable;

  always_ff @(posedge clk) begin
    if (rst) begin
      half_q <= HALF_W'(1);
      rate_q <= '0;
    end else if (accept) begin
      half_q <= half_cfg;
      rate_q <= rate;
    end
  end

  spi_sck_prescaler #(.W(HALF_W)) u_pre (
    .clk  (clk),
    .rst  (rst),
    .clr  (clr),
    .half (half_q),
    .tick (tick)
  );

  spi_sck_rate_div #(.W(RATE_W)) u_rate (
    .clk    (clk),
    .rst    (rst),
    .clr    (clr),
    .tick   (tick),
    .limit  (rate_q),
    .edge_o (edge_w)
  );

  spi_sck_edge_seq #(.LEN_W(LEN_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .start      (start),
    .cpol       (cpol),
    .cpha       (cpha),
    .bits_m1    (bits_m1),
    .edge_i     (edge_w),
    .sck        (sck),
    .sample_stb (sample_stb),
    .shift_stb  (shift_stb),
    .busy       (busy),
    .frame_done (frame_done)
  );

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(half_q) && $stable(rate_q));

endmodule

// File: tb/spi_sck_gen_bench.sv
module spi_sck_gen_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       enable = 1'b0, start = 1'b0, cpol = 1'b0, cpha = 1'b0;
  logic [7:0] prescale = 8'd2, rate = 8'd0;
  logic [3:0] bits_m1 = 4'd0;
  logic       sck, sample_stb, shift_stb, busy, frame_done;

  int n_tests = 0, n_fail = 0, cyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  spi_sck_gen u_spi_sck_gen (
    .clk(clk), .rst(rst), .enable(enable), .start(start), .cpol(cpol),
    .cpha(cpha), .prescale(prescale), .rate(rate), .bits_m1(bits_m1),
    .sck(sck), .sample_stb(sample_stb), .shift_stb(shift_stb),
    .busy(busy), .frame_done(frame_done)
  );

  // {cpol, cpha, prescale, rate, bits_m1}
  localparam logic [21:0] VEC [7] = '{
    {1'b0, 1'b0, 8'd2,  8'd0, 4'd7},
    {1'b1, 1'b0, 8'd6,  8'd2, 4'd3},
    {1'b0, 1'b1, 8'd4,  8'd1, 4'd4},
    {1'b1, 1'b1, 8'd10, 8'd0, 4'd15},
    {1'b0, 1'b0, 8'd7,  8'd1, 4'd2},
    {1'b1, 1'b1, 8'd1,  8'd3, 4'd1},
    {1'b0, 1'b1, 8'd0,  8'd0, 4'd0}
  };

  task automatic check(input bit ok, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic run_frame(input logic pol, input logic pha, input logic [7:0] p,
                           input logic [7:0] r, input logic [3:0] bm1, input int dist_at);
    int h, nb, el, last_el, ne, stray, lim;
    logic [7:0] pe;
    logic prev, exp_s, seen_done;
    pe = {p[7:1], 1'b0};
    if (pe < 8'd2) pe = 8'd2;
    h  = int'(pe / 2) * (int'(r) + 1);
    nb = int'(bm1) + 1;
    cpol = pol; cpha = pha; prescale = p; rate = r; bits_m1 = bm1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(sck === pol && busy === 1'b1, "R4 level at frame start", int'(sck), int'(pol));
    prev = pol; el = 0; last_el = 0; ne = 0; stray = 0; seen_done = 1'b0;
    lim = h * (2 * nb + 2) + 4;
    while (!seen_done && el < lim) begin
      @(negedge clk);
      el++;
      if (el == dist_at) begin
        start = 1'b1; rate = r + 8'd3; prescale = p + 8'd4;
        bits_m1 = bm1 + 4'd1; cpha = ~pha; cpol = ~pol;
      end else if (el == dist_at + 1) begin
        start = 1'b0;
      end
      if (sck !== prev) begin
        ne++;
        check(el - last_el == h, "R1 half period", el - last_el, h);
        last_el = el;
        prev = sck;
        exp_s = ((ne % 2) == 1) ^ pha;
        check(sample_stb === exp_s && shift_stb === !exp_s, "R6 strobe on edge",
              int'({sample_stb, shift_stb}), int'({exp_s, !exp_s}));
        check(frame_done === (ne == 2 * nb), "R5 done with last edge", int'(frame_done), int'(ne == 2 * nb));
        if (frame_done === 1'b1) seen_done = 1'b1;
      end else if (sample_stb || shift_stb || frame_done) begin
        stray++;
      end
    end
    check(ne == 2 * nb, "R5 edge count", ne, 2 * nb);
    check(stray == 0, "R6 stray strobes", stray, 0);
    check(sck === pol && busy === 1'b0, "R4 idle level after frame", int'(sck), int'(pol));
    cpol = pol;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(sck === 1'b0 && busy === 1'b0 && sample_stb === 1'b0 && shift_stb === 1'b0
          && frame_done === 1'b0, "R4 reset state", int'(sck), 0);
    rst = 1'b0;
    enable = 1'b1;
    @(negedge clk);

    // Table walk: all four modes, odd and sub-2 prescale (R2), fastest rate (R3)
    for (int i = 0; i < 7; i++)
      run_frame(VEC[i][21], VEC[i][20], VEC[i][19:12], VEC[i][11:4], VEC[i][3:0], 0);

    // R7: back-to-back frame, first half-period full length
    run_frame(1'b0, 1'b0, 8'd8, 8'd2, 4'd2, 0);
    run_frame(1'b1, 1'b0, 8'd8, 8'd2, 4'd2, 0);

    // R7 / R9: start and setting changes during a frame
    run_frame(1'b0, 1'b1, 8'd4, 8'd1, 4'd5, 3);

    // R3: slowest divisor, single-bit frame
    run_frame(1'b1, 1'b0, 8'd254, 8'd255, 4'd0, 0);

    // R4: idle level follows polarity
    cpol = 1'b1;
    @(negedge clk);
    check(sck === 1'b1, "R4 idle follows cpol", int'(sck), 1);
    cpol = 1'b0;
    @(negedge clk);
    check(sck === 1'b0, "R4 idle follows cpol low", int'(sck), 0);

    // R8: abort mid-frame
    cpol = 1'b1; cpha = 1'b0; prescale = 8'd4; rate = 8'd0; bits_m1 = 4'd7; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    check(busy === 1'b1, "R8 frame running before abort", int'(busy), 1);
    enable = 1'b0;
    @(negedge clk);
    check(busy === 1'b0 && sck === 1'b1, "R8 abort to idle", int'(busy), 0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    begin
      int bad;
      bad = 0;
      for (int k = 0; k < 10; k++) begin
        if (busy !== 1'b0 || sck !== 1'b1 || sample_stb !== 1'b0 || shift_stb !== 1'b0) bad++;
        @(negedge clk);
      end
      check(bad == 0, "R8 start ignored while disabled", bad, 0);
    end
    enable = 1'b1;
    @(negedge clk);
    run_frame(1'b1, 1'b1, 8'd6, 8'd1, 4'd3, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    wait (cyc >= 190000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected 0", cyc);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule